// File: doc/BRIEF.md
# TLB Random Replacement Index Generator

This block supplies the entry number that a random TLB replacement write should overwrite. It holds a 32-bit linear congruential seed. Each accepted request advances the seed one step, takes the upper sixteen bits of the new seed as a random source, and folds that source into the window of replaceable entries. The window runs from the wired count, which is the number of locked entries at the bottom of the TLB, up to the last entry. Entries below the wired count are therefore never chosen.

The fold is a remainder by the window size. A restoring divider computes it one source bit per cycle, so a result arrives a fixed number of cycles after the request. While the divider runs, the block ignores further requests. A finished index stays on the output, with its valid flag high, until the next request is accepted. If the wired count covers the whole TLB, no division is done: the block returns the last entry on the cycle after the request.

Top module: `tlbRandIdx`

## Requirements
- R1: A synchronous active-high reset sets the seed to zero, drops `indexValid`, drives `indexOut` to zero and abandons any computation in progress.
- R2: An accepted request replaces the seed S with (S * 314159 + 1) mod 2^32. From reset, the first three seeds are therefore 1, 314160 and 4206910929.
- R3: The random source is bits [31:16] of the updated seed, as an unsigned 16-bit number.
- R4: When the wired count W is below ENTRIES, the result is (source mod (ENTRIES - W)) + W. It never lies below W and never above ENTRIES-1.
- R5: When W is ENTRIES or more, the result is ENTRIES-1 and `indexValid` is high on the first cycle after the request edge. The seed still advances.
- R6: When W is below ENTRIES, `indexValid` is low for the first 15 cycles after the request edge and goes high on the 16th, with the result on `indexOut`.
- R7: A request is accepted only when no division is running. Requests during a division are ignored and do not advance the seed.
- R8: Once valid, `indexOut` and `indexValid` hold until the next accepted request, whatever the wired input does in the meantime.
- R9: The wired count is sampled on the request edge. Changes to `wiredCount` during the division do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe for a new replacement index |
| wiredCount | input | IDX_W+1 | Number of locked entries at the bottom of the TLB |
| indexOut | output | IDX_W | Selected entry number, IDX_W = clog2(ENTRIES) |
| indexValid | output | 1 | indexOut holds a finished result |

## Verification
The remainder path is driven with a wired count of zero, which uses the full sixteen-entry modulus, and with small and mid-range counts, where a wrong offset or a wrong divisor gives a different entry. The first results after reset are also checked against hand-computed values, which would expose a wrong multiplier or a wrong choice of seed bits. A wired count of ENTRIES-1 makes the window a single entry, and counts of ENTRIES and above exercise the path that skips the divider. Further tests send requests during a division and change the wired input in mid-run, then compare the following results with a model: a seed advanced by an ignored request, or a divisor taken from a late wired value, breaks the match. A reset during a division checks that the sequence restarts from a zero seed.

// File: rtl/tlbRandPkg.sv
package tlbRandPkg;
  localparam int SEED_W = 32;
  localparam int SRC_W  = 16;
  localparam logic [SEED_W-1:0] LCG_MUL = 32'd314159;
  localparam logic [SEED_W-1:0] LCG_INC = 32'd1;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;    // request taken: advance seed, load divider
    logic saturate;  // wired covers whole TLB: write last entry now
    logic step;      // one restoring division iteration
    logic finish;    // last iteration: publish the index
  } tlbRandCtrl_t;
endpackage

// File: rtl/tlbRandCtrl.sv
module tlbRandCtrl
  import tlbRandPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         reqValid,
  input  logic         wiredFull,
  output tlbRandCtrl_t ctrl
);
  localparam int CNT_W = $clog2(SRC_W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(SRC_W - 1);

  typedef enum logic {ST_IDLE, ST_DIV} state_t;

  state_t stateQ;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    ctrl.accept   = reqValid && (stateQ == ST_IDLE);
    ctrl.saturate = ctrl.accept && wiredFull;
    ctrl.step     = (stateQ == ST_DIV);
    ctrl.finish   = ctrl.step && (stepCnt == LAST_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ  <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      if (ctrl.accept && !wiredFull) begin
        stateQ  <= ST_DIV;
        stepCnt <= '0;
      end else if (ctrl.step) begin
        stepCnt <= stepCnt + 1'b1;
        if (ctrl.finish) stateQ <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/tlbRandPath.sv
module tlbRandPath
  import tlbRandPkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int WIRED_W = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  tlbRandCtrl_t       ctrl,
  input  logic [WIRED_W-1:0] wiredCount,
  output logic               wiredFull,
  output logic [SEED_W-1:0]  seedOut,
  output logic [IDX_W-1:0]   indexOut,
  output logic               indexValid
);
  localparam int REM_W = WIRED_W + 1;
  localparam logic [WIRED_W-1:0] ENTRIES_W = WIRED_W'(ENTRIES);
  localparam logic [IDX_W-1:0]   LAST_IDX  = IDX_W'(ENTRIES - 1);

  logic [SEED_W-1:0]  seedQ;
  logic [SEED_W-1:0]  seedNext;
  logic [WIRED_W-1:0] wiredQ;
  logic [WIRED_W-1:0] spanQ;
  logic [SRC_W-1:0]   divQ;
  logic [REM_W-1:0]   remQ;
  logic [REM_W-1:0]   shifted;
  logic [REM_W-1:0]   remStep;

  assign seedNext  = seedQ * LCG_MUL + LCG_INC;
  assign wiredFull = (wiredCount >= ENTRIES_W);
  assign seedOut   = seedQ;

  always_comb begin
    shifted = {remQ[REM_W-2:0], divQ[SRC_W-1]};
    if (shifted >= {1'b0, spanQ}) remStep = shifted - {1'b0, spanQ};
    else                          remStep = shifted;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seedQ      <= '0;
      wiredQ     <= '0;
      spanQ      <= '0;
      divQ       <= '0;
      remQ       <= '0;
      indexOut   <= '0;
      indexValid <= 1'b0;
    end else begin
      if (ctrl.accept) begin
        seedQ  <= seedNext;
        wiredQ <= wiredCount;
        spanQ  <= ENTRIES_W - wiredCount;
        divQ   <= seedNext[SEED_W-1 -: SRC_W];
        remQ   <= '0;
        if (ctrl.saturate) begin
          indexOut   <= LAST_IDX;
          indexValid <= 1'b1;
        end else begin
          indexValid <= 1'b0;
        end
      end
      if (ctrl.step) begin
        divQ <= divQ << 1;
        remQ <= remStep;
        if (ctrl.finish) begin
          indexOut   <= IDX_W'(remStep + REM_W'(wiredQ));
          indexValid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tlbRandIdx.sv
module tlbRandIdx
  import tlbRandPkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int WIRED_W = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  logic [WIRED_W-1:0] wiredCount,
  output logic [IDX_W-1:0]   indexOut,
  output logic               indexValid
);
  tlbRandCtrl_t      ctrlBus;
  logic              wiredFull;
  logic [SEED_W-1:0] seedVal;

  tlbRandCtrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .wiredFull(wiredFull),
    .ctrl     (ctrlBus)
  );

  tlbRandPath #(.ENTRIES(ENTRIES)) u_path (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrlBus),
    .wiredCount(wiredCount),
    .wiredFull (wiredFull),
    .seedOut   (seedVal),
    .indexOut  (indexOut),
    .indexValid(indexValid)
  );
endmodule

// File: rtl/tlbRandChecker.sv
module tlbRandChecker
  import tlbRandPkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int WIRED_W = IDX_W + 1
) (
  input logic               clk,
  input logic               rst,
  input logic [WIRED_W-1:0] wiredCount,
  input logic [IDX_W-1:0]   indexOut,
  input logic               indexValid,
  input tlbRandCtrl_t       ctrl,
  input logic [SEED_W-1:0]  seed
);
  localparam logic [WIRED_W-1:0] ENTRIES_W = WIRED_W'(ENTRIES);
  localparam logic [IDX_W-1:0]   LAST_IDX  = IDX_W'(ENTRIES - 1);

  logic [WIRED_W-1:0] capWired;
  always_ff @(posedge clk) begin
    if (rst) capWired <= '0;
    else if (ctrl.accept) capWired <= wiredCount;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> !indexValid && (seed == '0));

  p_lcg_step_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl.accept |=> seed == ($past(seed) * LCG_MUL + LCG_INC));

  p_index_floor_r4: assert property (@(posedge clk) disable iff (rst)
    (indexValid && capWired < ENTRIES_W) |-> ({1'b0, indexOut} >= capWired));

  p_saturate_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrl.accept && wiredCount >= ENTRIES_W) |=> indexValid && (indexOut == LAST_IDX));

  p_valid_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.accept && wiredCount < ENTRIES_W) |=> !indexValid);

  p_seed_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !ctrl.accept |=> $stable(seed));

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.accept, ctrl.step}));

  p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (indexValid && !ctrl.accept) |=> indexValid && $stable(indexOut));
endmodule

bind tlbRandIdx tlbRandChecker #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wiredCount(wiredCount),
  .indexOut  (indexOut),
  .indexValid(indexValid),
  .ctrl      (ctrlBus),
  .seed      (seedVal)
);

// File: tb/test_tlbRandIdx.sv
module test_tlbRandIdx;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 16;
  localparam int IDX_W      = $clog2(ENTRIES);
  localparam int WIRED_W    = IDX_W + 1;
  localparam int DIV_CYCLES = 16;

  typedef struct packed {
    int wired;   // wired count on the request
    int expIdx;  // hand value, -1 means use the model
    int poke;    // extra request during the division
    int swapTo;  // wired value driven during division, -1 means keep
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{0,  0,  0, -1},
    '{3,  7,  0, -1},
    '{5,  12, 0, -1},
    '{15, 15, 1, -1},
    '{16, 15, 0, -1},
    '{1,  -1, 0, 2},
    '{0,  -1, 1, 9},
    '{31, 15, 0, -1},
    '{8,  -1, 0, -1},
    '{12, -1, 1, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic [WIRED_W-1:0] wiredCount = '0;
  logic [IDX_W-1:0] indexOut;
  logic indexValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] modelSeed = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlbRandIdx #(.ENTRIES(ENTRIES)) i_tlbRandIdx (
    .clk(clk), .rst(rst), .reqValid(reqValid), .wiredCount(wiredCount),
    .indexOut(indexOut), .indexValid(indexValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int modelIndex(input int w);
    int src;
    modelSeed = modelSeed * 32'd314159 + 32'd1;
    src = int'(modelSeed[31:16]);
    if (w >= ENTRIES) return ENTRIES - 1;
    return (src % (ENTRIES - w)) + w;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    reqValid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    modelSeed = '0;
  endtask

  // one request; returns after the result should be visible
  task automatic runRequest(input int w, input int expIdx, input int poke, input int swapTo);
    int exp;
    bit earlyBad;
    exp = modelIndex(w);
    if (expIdx >= 0) exp = expIdx;
    @(negedge clk);
    reqValid = 1'b1;
    wiredCount = WIRED_W'(w);
    @(negedge clk);
    reqValid = 1'b0;
    if (w >= ENTRIES) begin
      check(indexValid === 1'b1, "R5 valid", int'(indexValid), 1);
      check(indexOut == IDX_W'(exp), "R5 index", int'(indexOut), exp);
    end else begin
      check(indexValid === 1'b0, "R6 valid drop", int'(indexValid), 0);
      if (swapTo >= 0) wiredCount = WIRED_W'(swapTo);
      earlyBad = 1'b0;
      for (int k = 1; k <= DIV_CYCLES; k++) begin
        reqValid = (poke != 0) && (k == 4);
        @(negedge clk);
        if (k < DIV_CYCLES && indexValid !== 1'b0) earlyBad = 1'b1;
      end
      reqValid = 1'b0;
      check(!earlyBad, "R6 early valid", int'(earlyBad), 0);
      check(indexValid === 1'b1, "R6 valid at 16", int'(indexValid), 1);
      check(indexOut == IDX_W'(exp), "R4 R7 R9 index", int'(indexOut), exp);
    end
  endtask

  initial begin
    logic [IDX_W-1:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(indexValid === 1'b0, "R1 valid after reset", int'(indexValid), 0);
    check(indexOut == '0, "R1 index after reset", int'(indexOut), 0);
    doReset();

    // R2 R3 R4: table walk, first three against hand values
    for (int i = 0; i < NVEC; i++)
      runRequest(VECS[i].wired, VECS[i].expIdx, VECS[i].poke, VECS[i].swapTo);

    // R8: result holds while wired input moves
    held = indexOut;
    for (int k = 0; k < 6; k++) begin
      wiredCount = WIRED_W'(k * 5);
      @(negedge clk);
    end
    check(indexValid === 1'b1, "R8 valid hold", int'(indexValid), 1);
    check(indexOut == held, "R8 index hold", int'(indexOut), int'(held));

    // R1: reset during a division, then sequence restarts
    @(negedge clk);
    reqValid = 1'b1;
    wiredCount = '0;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    modelSeed = '0;
    check(indexValid === 1'b0, "R1 valid after mid reset", int'(indexValid), 0);
    repeat (DIV_CYCLES + 2) @(negedge clk);
    check(indexValid === 1'b0, "R1 no stale result", int'(indexValid), 0);
    runRequest(0, 0, 0, -1);
    runRequest(2, 6, 0, -1);

    // R4: a run of mixed wired counts against the model
    for (int i = 0; i < 12; i++) runRequest((i * 7) % 15, -1, 0, -1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule